// File: doc/BRIEF.md
# UART Extended Control and Baud Prescaler

This block holds the extended control byte of a UART and drives the logic that hangs off it. Software reaches the byte over a simple register bus. The block decodes the byte into three things. The first is a 16-or-32 entry depth select for each of the transmit and receive FIFOs. The second is a clock-enable pulse train that paces the baud generator, with a prescale ratio of 13, 13/8 or 1 relative to the main clock. The third is the steering of bus accesses aimed at the two baud-divisor byte addresses.

The divisor steering depends on a lock bit and on the bank mode. While the lock is set and the bank is not in extended mode, reads and writes at the divisor addresses land in two scratchpad bytes inside this block. The real divisor and the fallback path are then left alone. In extended mode the lock is ignored.

The prescaler is a small state machine with one state per ratio: `PS_DIV13`, `PS_FRAC`, `PS_DIV1` and `PS_HOLD` (reserved code). Its transitions are as follows:
- When the ratio field decodes to a different state, the machine takes the *retarget* transition into that state. This transition clears its counter and suppresses the enable for that cycle.
- Otherwise the machine takes the *run* transition and stays in its state. In `PS_DIV13` the counter cycles 0..12. In `PS_FRAC` a phase accumulator adds 8 modulo 13.

Top module: `uart_xctl`

## Requirements
- R1: After reset the control byte reads 0x00, both depth outputs are 0, `fallback_en` is 1, and the prescaler runs at divide-by-13.
- R2: A write to the control address stores the byte, except bit 6, which always reads back 0. A read at the control address returns the stored byte.
- R3: The transmit depth is taken from bits 1:0. `tx_lvl32` is 1 only for code 01, meaning 32 entries. Code 00 and codes 1x give 16 entries, shown as `tx_lvl32`=0.
- R4: The receive depth is taken from bits 3:2 with the same coding, shown on `rx_lvl32`.
- R5: While `fifo_en` is 0, both `tx_lvl32` and `rx_lvl32` are 0, whatever the byte holds.
- R6: Ratio code 00 (bits 5:4) gives a one-cycle `baud_ce` pulse once every 13 clocks, never on two consecutive cycles.
- R7: Ratio code 01 gives exactly 8 `baud_ce` pulses in every 13 consecutive clocks.
- R8: Ratio code 11 holds `baud_ce` high. Reserved code 10 gives no pulses.
- R9: When the ratio field changes, the prescaler restarts. Take the edge that stores the write as edge 0. Under code 00, `baud_ce` is first high after edge 13. Under code 01, it is first high after edge 2.
- R10: With lock (bit 7) = 1 and `ext_mode` = 0, `fallback_en` is 0. Divisor low and high writes raise no `div_we_lo`/`div_we_hi`; they go to two scratchpads, and reads return the scratchpads. The real divisor keeps its value.
- R11: With `ext_mode` = 1 the lock bit has no effect: divisor writes raise the divisor strobes and `fallback_en` is 1.
- R12: With lock = 0, a divisor write raises the matching strobe, and a divisor read returns `div_lo_q`/`div_hi_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| ext_mode | input | 1 | Register bank in extended mode |
| bus_addr | input | 3 | Register address (divisor low 0, high 1, control 2) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| div_lo_q | input | 8 | Current real divisor low byte |
| div_hi_q | input | 8 | Current real divisor high byte |
| div_we_lo | output | 1 | Write strobe to real divisor low byte |
| div_we_hi | output | 1 | Write strobe to real divisor high byte |
| div_wdata | output | 8 | Data for the real divisor |
| fallback_en | output | 1 | Fallback permitted (lock not in force) |
| tx_lvl32 | output | 1 | Transmit FIFO depth 32 (0 = 16) |
| rx_lvl32 | output | 1 | Receive FIFO depth 32 (0 = 16) |
| baud_ce | output | 1 | Baud generator clock enable |

## Verification
The bench builds the block with its default parameters: a prescale modulus of 13, a fractional step of 8, and divisor and control addresses 0, 1 and 2. With these values, a 26-cycle window holds exactly two full periods of every ratio. The exact pulse counts (2, 16, 26, 0) are therefore fixed regardless of phase, and the restart latency after a ratio change can be pinned to a single edge. The 3-bit address reaches every steering path, including the lock/extended-mode interplay, within a handful of bus cycles.

// File: rtl/uart_xctl_pkg.sv
package uart_xctl_pkg;

    typedef enum logic [1:0] {
        PS_DIV13 = 2'b00,
        PS_FRAC  = 2'b01,
        PS_HOLD  = 2'b10,
        PS_DIV1  = 2'b11
    } presc_e;

    localparam int TXSZ_LSB = 0;
    localparam int RXSZ_LSB = 2;
    localparam int PS_LSB   = 4;
    localparam int RSV_BIT  = 6;
    localparam int LOCK_BIT = 7;

    function automatic logic size_is_32(input logic [1:0] code);
        return code == 2'b01;
    endfunction

endpackage

// File: rtl/uart_xctl_regs.sv
module uart_xctl_regs
    import uart_xctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int DLO_ADDR = 0,
    parameter int DHI_ADDR = 1,
    parameter int CTL_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] div_lo_q,
    input  logic [DATA_W-1:0] div_hi_q,
    output logic              div_we_lo,
    output logic              div_we_hi,
    output logic              fallback_en,
    output logic              tx_lvl32,
    output logic              rx_lvl32,
    output presc_e            ps_mode
);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(DLO_ADDR);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(DHI_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
    localparam logic [DATA_W-1:0] KEEP  = ~(DATA_W'(1) << RSV_BIT);

    logic [DATA_W-1:0] ctl_q, pad_lo_q, pad_hi_q;
    logic              redirect;
    logic              hit_lo, hit_hi, hit_ctl;

    assign hit_lo   = bus_addr == A_LO;
    assign hit_hi   = bus_addr == A_HI;
    assign hit_ctl  = bus_addr == A_CTL;
    assign redirect = ctl_q[LOCK_BIT] & ~ext_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            pad_lo_q <= '0;
            pad_hi_q <= '0;
        end else if (bus_wr) begin
            if (hit_ctl)             ctl_q    <= bus_wdata & KEEP;
            if (hit_lo && redirect)  pad_lo_q <= bus_wdata;
            if (hit_hi && redirect)  pad_hi_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctl)     bus_rdata = ctl_q;
        else if (hit_lo) bus_rdata = redirect ? pad_lo_q : div_lo_q;
        else if (hit_hi) bus_rdata = redirect ? pad_hi_q : div_hi_q;
    end

    assign div_we_lo   = bus_wr & hit_lo & ~redirect;
    assign div_we_hi   = bus_wr & hit_hi & ~redirect;
    assign fallback_en = ~redirect;
    assign tx_lvl32    = fifo_en & size_is_32(ctl_q[TXSZ_LSB +: 2]);
    assign rx_lvl32    = fifo_en & size_is_32(ctl_q[RXSZ_LSB +: 2]);
    assign ps_mode     = presc_e'(ctl_q[PS_LSB +: 2]);

endmodule

// File: rtl/uart_xctl_presc.sv
module uart_xctl_presc
    import uart_xctl_pkg::*;
#(
    parameter int DIV_N     = 13,
    parameter int FRAC_STEP = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  presc_e ps_mode,
    output logic   baud_ce
);
    localparam int CNT_W = $clog2(DIV_N);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] MOD_S  = SUM_W'(DIV_N);
    localparam logic [SUM_W-1:0] STEP_S = SUM_W'(FRAC_STEP);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV_N - 1);

    presc_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  sum;
    logic              wrap, retarget;

    assign sum      = {1'b0, cnt_q} + STEP_S;
    assign wrap     = sum >= MOD_S;
    assign retarget = ps_mode != state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_DIV13;
            cnt_q   <= '0;
        end else if (retarget) begin
            state_q <= ps_mode;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                PS_DIV13: cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                PS_FRAC:  cnt_q <= wrap ? CNT_W'(sum - MOD_S) : CNT_W'(sum);
                PS_DIV1:  cnt_q <= cnt_q;
                PS_HOLD:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        baud_ce = 1'b0;
        if (!retarget) begin
            unique case (state_q)
                PS_DIV13: baud_ce = cnt_q == LAST;
                PS_FRAC:  baud_ce = wrap;
                PS_DIV1:  baud_ce = 1'b1;
                PS_HOLD:  baud_ce = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/uart_xctl.sv
module uart_xctl
    import uart_xctl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int DLO_ADDR  = 0,
    parameter int DHI_ADDR  = 1,
    parameter int CTL_ADDR  = 2,
    parameter int DIV_N     = 13,
    parameter int FRAC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] div_lo_q,
    input  logic [DATA_W-1:0] div_hi_q,
    output logic              div_we_lo,
    output logic              div_we_hi,
    output logic [DATA_W-1:0] div_wdata,
    output logic              fallback_en,
    output logic              tx_lvl32,
    output logic              rx_lvl32,
    output logic              baud_ce
);
    presc_e ps_mode;

    uart_xctl_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .DLO_ADDR(DLO_ADDR), .DHI_ADDR(DHI_ADDR), .CTL_ADDR(CTL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_mode(ext_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .div_lo_q(div_lo_q), .div_hi_q(div_hi_q),
        .div_we_lo(div_we_lo), .div_we_hi(div_we_hi),
        .fallback_en(fallback_en), .tx_lvl32(tx_lvl32), .rx_lvl32(rx_lvl32),
        .ps_mode(ps_mode)
    );

    uart_xctl_presc #(.DIV_N(DIV_N), .FRAC_STEP(FRAC_STEP)) u_presc (
        .clk(clk), .rst_n(rst_n), .ps_mode(ps_mode), .baud_ce(baud_ce)
    );

    assign div_wdata = bus_wdata;

endmodule

// File: rtl/uart_xctl_chk.sv
module uart_xctl_chk
    import uart_xctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int DLO_ADDR = 0,
    parameter int DHI_ADDR = 1,
    parameter int CTL_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic              ext_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              div_we_lo,
    input logic              div_we_hi,
    input logic              fallback_en,
    input logic              tx_lvl32,
    input logic              rx_lvl32,
    input logic              baud_ce,
    input presc_e            ps_mode
);
    logic div_access;
    assign div_access = bus_wr && (bus_addr == ADDR_W'(DLO_ADDR) || bus_addr == ADDR_W'(DHI_ADDR));

    p_rsv_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(CTL_ADDR) |-> !bus_rdata[RSV_BIT]);

    p_fifo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (!tx_lvl32 && !rx_lvl32));

    p_div13_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_mode == PS_DIV13 && baud_ce) |=> !baud_ce);

    p_div1_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_mode == PS_DIV1 && $past(ps_mode) == PS_DIV1) |-> baud_ce);

    p_hold_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ps_mode == PS_HOLD |-> !baud_ce);

    p_lock_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fallback_en && div_access) |-> (!div_we_lo && !div_we_hi));

    p_ext_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && div_access) |-> (fallback_en && (div_we_lo || div_we_hi)));

endmodule

bind uart_xctl uart_xctl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DLO_ADDR(DLO_ADDR), .DHI_ADDR(DHI_ADDR), .CTL_ADDR(CTL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_mode(ext_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .div_we_lo(div_we_lo), .div_we_hi(div_we_hi), .fallback_en(fallback_en),
    .tx_lvl32(tx_lvl32), .rx_lvl32(rx_lvl32), .baud_ce(baud_ce),
    .ps_mode(ps_mode)
);

// File: tb/uart_xctl_tb.sv
module uart_xctl_tb;
    localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_CTL = 3'd2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       fifo_en = 1'b1, ext_mode = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = A_CTL;
    logic [7:0] bus_wdata = '0, bus_rdata, div_wdata;
    logic [7:0] div_lo_m = 8'h00, div_hi_m = 8'h00;
    logic       div_we_lo, div_we_hi, fallback_en, tx_lvl32, rx_lvl32, baud_ce;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    uart_xctl u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_mode(ext_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .div_lo_q(div_lo_m), .div_hi_q(div_hi_m),
        .div_we_lo(div_we_lo), .div_we_hi(div_we_hi), .div_wdata(div_wdata),
        .fallback_en(fallback_en), .tx_lvl32(tx_lvl32), .rx_lvl32(rx_lvl32),
        .baud_ce(baud_ce)
    );

    // model of the real divisor that lives outside the block
    always @(posedge clk) begin
        if (div_we_lo) div_lo_m <= div_wdata;
        if (div_we_hi) div_hi_m <= div_wdata;
    end

    // {wdata, expected readback, tx32, rx32, pulses in 26 clocks}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 6'd2},
        {8'h05, 8'h05, 1'b1, 1'b1, 6'd2},
        {8'h11, 8'h11, 1'b1, 1'b0, 6'd16},
        {8'h34, 8'h34, 1'b0, 1'b1, 6'd26},
        {8'h2A, 8'h2A, 1'b0, 1'b0, 6'd0},
        {8'h4E, 8'h0E, 1'b0, 1'b0, 6'd2},
        {8'h71, 8'h31, 1'b1, 1'b0, 6'd26},
        {8'h9D, 8'h9D, 1'b1, 1'b0, 6'd16}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_ce) c++;
        end
    endtask

    task automatic first_pulse(output int k);
        k = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (baud_ce) begin k = i; break; end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int c, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTL, d);
        check(d == 8'h00, "R1 ctl", d, 0);
        check(!tx_lvl32 && !rx_lvl32, "R1 depth", {tx_lvl32, rx_lvl32}, 0);
        check(fallback_en, "R1 fallback", fallback_en, 1);
        pulses(26, c);
        check(c == 2, "R1 div13", c, 2);

        // R2 R3 R4 R6 R7 R8: vector table
        foreach (VEC[i]) begin
            wr(A_CTL, VEC[i][23:16]);
            rd(A_CTL, d);
            check(d == VEC[i][15:8], "R2 readback", d, VEC[i][15:8]);
            check(tx_lvl32 == VEC[i][7], "R3 tx depth", tx_lvl32, VEC[i][7]);
            check(rx_lvl32 == VEC[i][6], "R4 rx depth", rx_lvl32, VEC[i][6]);
            pulses(2, c);
            pulses(26, c);
            check(c == int'(VEC[i][5:0]), "R6/R7/R8 pulses", c, VEC[i][5:0]);
        end

        // R5: FIFOs disabled
        wr(A_CTL, 8'h05);
        fifo_en = 1'b0;
        #1 check(!tx_lvl32 && !rx_lvl32, "R5 disabled", {tx_lvl32, rx_lvl32}, 0);
        fifo_en = 1'b1;
        #1 check(tx_lvl32 && rx_lvl32, "R5 enabled", {tx_lvl32, rx_lvl32}, 3);

        // R9: restart on ratio change
        wr(A_CTL, 8'h30);
        pulses(3, c);
        wr(A_CTL, 8'h00);
        first_pulse(k);
        check(k == 13, "R9 div13 first", k, 13);
        wr(A_CTL, 8'h10);
        first_pulse(k);
        check(k == 2, "R9 frac first", k, 2);

        // R12: unlocked divisor access
        wr(A_CTL, 8'h00);
        @(negedge clk);
        bus_addr = A_LO; bus_wdata = 8'h5A; bus_wr = 1'b1;
        #1 check(div_we_lo && !div_we_hi, "R12 strobe", {div_we_lo, div_we_hi}, 2);
        @(negedge clk); bus_wr = 1'b0;
        wr(A_HI, 8'hA5);
        rd(A_LO, d);
        check(d == 8'h5A, "R12 read lo", d, 8'h5A);
        rd(A_HI, d);
        check(d == 8'hA5, "R12 read hi", d, 8'hA5);

        // R10: lock in non-extended mode
        wr(A_CTL, 8'h80);
        #1 check(!fallback_en, "R10 fallback", fallback_en, 0);
        @(negedge clk);
        bus_addr = A_LO; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1 check(!div_we_lo, "R10 no strobe", div_we_lo, 0);
        @(negedge clk); bus_wr = 1'b0;
        wr(A_HI, 8'h11);
        rd(A_LO, d);
        check(d == 8'hC3, "R10 pad lo", d, 8'hC3);
        rd(A_HI, d);
        check(d == 8'h11, "R10 pad hi", d, 8'h11);
        wr(A_CTL, 8'h00);
        rd(A_LO, d);
        check(d == 8'h5A, "R10 real lo kept", d, 8'h5A);
        rd(A_HI, d);
        check(d == 8'hA5, "R10 real hi kept", d, 8'hA5);

        // R11: extended mode ignores lock
        wr(A_CTL, 8'h80);
        ext_mode = 1'b1;
        #1 check(fallback_en, "R11 fallback", fallback_en, 1);
        @(negedge clk);
        bus_addr = A_LO; bus_wdata = 8'h77; bus_wr = 1'b1;
        #1 check(div_we_lo, "R11 strobe", div_we_lo, 1);
        @(negedge clk); bus_wr = 1'b0;
        rd(A_LO, d);
        check(d == 8'h77, "R11 read", d, 8'h77);
        ext_mode = 1'b0;

        finish_run();
    end
endmodule